// File: doc/BRIEF.md
# Per-Channel Burst Batching Write Engine

This block takes one stream of data words, each carrying a small tag that names the memory channel it belongs to, and turns that stream into long, address-sequential write bursts on a set of independent channel master ports. A steering stage routes every accepted word into a batch buffer owned by its target channel. Each channel then drains its buffer in fixed-size bursts to its own write port, so words that arrive for different channels in scattered order still leave as long sequential transfers.

Each channel write port has an address phase (valid/ready with address and beat count), a data phase (valid/ready with data and a last-beat flag) and a single-beat completion handshake. Every channel starts writing at its own base address, which is the channel index times a fixed span. After each finished burst it moves forward by the number of bytes it has just written. A flush pulse makes every channel that holds an incomplete batch send it as a shorter burst. A tag that names no channel is reported on an error output and the word is dropped.

Top module: `burst_batcher`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `tag_err` and every per-channel `awvalid`, `wvalid` and `bready` are 0.
- R2: A word accepted with tag c (c below NUM_CH) is written on channel c only, and the words of one channel leave in their order of acceptance.
- R3: A channel issues a burst only when its buffer holds at least BURST_LEN words, unless a flush is pending. A full burst shows `awlen` = BURST_LEN-1 and carries exactly BURST_LEN beats. `wlast` is 1 only on its final beat.
- R4: Channel c writes its first burst at address c*CH_SPAN. When the completion handshake of a burst of n beats finishes, the channel's next address is larger by n*DATA_W/8.
- R5: While the buffer of a valid target tag holds FIFO_DEPTH words, `in_ready` is 0. The stalled word is accepted later and is not lost.
- R6: A one-cycle `flush` makes each channel holding k words, with 0 < k < BURST_LEN, send one burst of k beats (`awlen` = k-1). A channel whose buffer is empty sends nothing.
- R7: A word whose tag is NUM_CH or larger is accepted with `in_ready` at 1 and then discarded. `tag_err` is 1 in the cycle after that acceptance, and no channel writes the word.
- R8: On each channel the address handshake comes before any data beat. A data beat that is stalled by `wready` keeps its valid and data unchanged. The channel waits for `bvalid` before it starts another burst.
- R9: A raised `awvalid` stays 1 with the address unchanged until `awready` is seen.

Field layout: the per-channel buses are packed with channel c at bits [c*W +: W] for every per-channel field of width W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle |
| in_data | input | DATA_W | Input word |
| in_tag | input | TAG_W = clog2(NUM_CH) | Target channel index |
| flush | input | 1 | Drain partial batches |
| tag_err | output | 1 | Pulse: an out-of-range tag was dropped |
| ch_awvalid | output | NUM_CH | Address phase valid per channel |
| ch_awready | input | NUM_CH | Address phase ready per channel |
| ch_awaddr | output | NUM_CH*ADDR_W | Burst start address per channel |
| ch_awlen | output | NUM_CH*8 | Beats minus one per channel |
| ch_wvalid | output | NUM_CH | Data beat valid per channel |
| ch_wready | input | NUM_CH | Data beat ready per channel |
| ch_wdata | output | NUM_CH*DATA_W | Data beat per channel |
| ch_wlast | output | NUM_CH | Final beat of burst per channel |
| ch_bvalid | input | NUM_CH | Completion valid per channel |
| ch_bready | output | NUM_CH | Completion ready per channel |

## Verification
The first input pattern interleaves tags across all channels in scrambled order and mixes in illegal tags. It shows whether steering keeps per-channel order, whether dropped words leak onto any port, and whether one burst fires per channel at exactly the batch size. A second pattern fills one channel again while its data ready stutters. This separates correct beat holding and address advance from simple pass-through. A partial batch followed by a flush shows whether short bursts are held back until the flush and then sized to the leftover count. A final pattern blocks the address ready until the buffer is full, to show the stall on the input and that no word is lost.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ADDR,
    WS_DATA,
    WS_RESP
  } wr_state_e;
endpackage

// File: rtl/bb_fifo.sv
// Batch buffer: registered show-ahead read, memory free of reset so it maps to block RAM.
module bb_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp, rp_next;

  assign rp_next = pop ? rp + PW'(1) : rp;
  assign full    = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
    rd_data <= mem[rp_next];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      rp <= rp_next;
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/bb_splitter.sv
// Steers the input word to the buffer named by its tag.
module bb_splitter #(
  parameter int NUM_CH = 8,
  parameter int TAG_W  = 3
) (
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [NUM_CH-1:0] full,
  output logic              in_ready,
  output logic              tag_bad,
  output logic [NUM_CH-1:0] push
);
  always_comb begin
    tag_bad  = ({1'b0, in_tag} >= (TAG_W+1)'(NUM_CH));
    in_ready = 1'b1;
    push     = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (!tag_bad && in_tag == TAG_W'(c)) begin
        in_ready = !full[c];
        push[c]  = in_valid && !full[c];
      end
    end
  end
endmodule

// File: rtl/bb_ch_writer.sv
// One channel: launches bursts from its buffer and tracks its write address.
module bb_ch_writer
  import bb_pkg::*;
#(
  parameter int              DATA_W    = 512,
  parameter int              ADDR_W    = 32,
  parameter int              BURST_LEN = 16,
  parameter int              DEPTH     = 64,
  parameter logic [ADDR_W-1:0] BASE    = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  output logic                       pop,
  output logic                       awvalid,
  input  logic                       awready,
  output logic [ADDR_W-1:0]          awaddr,
  output logic [7:0]                 awlen,
  output logic                       wvalid,
  input  logic                       wready,
  output logic                       wlast,
  input  logic                       bvalid,
  output logic                       bready
);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int LW    = $clog2(BURST_LEN+1);
  localparam int BYTES = DATA_W / 8;

  wr_state_e     state;
  logic [LW-1:0] len, beat, len_next;
  logic          flush_pend, have_full, launch;

  assign have_full = (fifo_cnt >= CW'(BURST_LEN));
  assign launch    = (state == WS_IDLE) && (have_full || (flush_pend && fifo_cnt != '0));
  assign len_next  = have_full ? LW'(BURST_LEN) : LW'(fifo_cnt);
  assign pop       = (state == WS_DATA) && wvalid && wready;
  assign awlen     = 8'(len) - 8'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      awvalid    <= 1'b0;
      wvalid     <= 1'b0;
      wlast      <= 1'b0;
      bready     <= 1'b0;
      awaddr     <= BASE;
      len        <= '0;
      beat       <= '0;
      flush_pend <= 1'b0;
    end else begin
      if (flush)
        flush_pend <= 1'b1;
      else if (state == WS_IDLE && fifo_cnt <= CW'(BURST_LEN))
        flush_pend <= 1'b0;

      case (state)
        WS_IDLE: begin
          if (launch) begin
            len     <= len_next;
            awvalid <= 1'b1;
            state   <= WS_ADDR;
          end
        end
        WS_ADDR: begin
          if (awready) begin
            awvalid <= 1'b0;
            wvalid  <= 1'b1;
            beat    <= '0;
            wlast   <= (len == LW'(1));
            state   <= WS_DATA;
          end
        end
        WS_DATA: begin
          if (wready) begin
            if (wlast) begin
              wvalid <= 1'b0;
              wlast  <= 1'b0;
              bready <= 1'b1;
              state  <= WS_RESP;
            end else begin
              beat  <= beat + LW'(1);
              wlast <= ((LW+1)'(beat) + (LW+1)'(2) == (LW+1)'(len));
            end
          end
        end
        WS_RESP: begin
          if (bvalid) begin
            bready <= 1'b0;
            awaddr <= awaddr + ADDR_W'(len) * ADDR_W'(BYTES);
            state  <= WS_IDLE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_batcher.sv
module burst_batcher #(
  parameter int                NUM_CH     = 8,
  parameter int                DATA_W     = 512,
  parameter int                ADDR_W     = 32,
  parameter int                FIFO_DEPTH = 64,
  parameter int                BURST_LEN  = 16,
  parameter logic [ADDR_W-1:0] CH_SPAN    = 32'h1000_0000,
  localparam int               TAG_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic                     flush,
  output logic                     tag_err,
  output logic [NUM_CH-1:0]        ch_awvalid,
  input  logic [NUM_CH-1:0]        ch_awready,
  output logic [NUM_CH*ADDR_W-1:0] ch_awaddr,
  output logic [NUM_CH*8-1:0]      ch_awlen,
  output logic [NUM_CH-1:0]        ch_wvalid,
  input  logic [NUM_CH-1:0]        ch_wready,
  output logic [NUM_CH*DATA_W-1:0] ch_wdata,
  output logic [NUM_CH-1:0]        ch_wlast,
  input  logic [NUM_CH-1:0]        ch_bvalid,
  output logic [NUM_CH-1:0]        ch_bready
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [NUM_CH-1:0] push, full, pop;
  logic              tag_bad;

  bb_splitter #(.NUM_CH(NUM_CH), .TAG_W(TAG_W)) u_split (
    .in_valid (in_valid),
    .in_tag   (in_tag),
    .full     (full),
    .in_ready (in_ready),
    .tag_bad  (tag_bad),
    .push     (push)
  );

  always_ff @(posedge clk) begin
    if (rst) tag_err <= 1'b0;
    else     tag_err <= in_valid && tag_bad;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_BASE = ADDR_W'(c) * CH_SPAN;
    logic [CW-1:0] cnt;

    bb_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push      (push[c]),
      .push_data (in_data),
      .pop       (pop[c]),
      .rd_data   (ch_wdata[c*DATA_W +: DATA_W]),
      .count     (cnt),
      .full      (full[c])
    );

    bb_ch_writer #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .BURST_LEN (BURST_LEN),
      .DEPTH     (FIFO_DEPTH),
      .BASE      (CH_BASE)
    ) u_wr (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .fifo_cnt (cnt),
      .pop      (pop[c]),
      .awvalid  (ch_awvalid[c]),
      .awready  (ch_awready[c]),
      .awaddr   (ch_awaddr[c*ADDR_W +: ADDR_W]),
      .awlen    (ch_awlen[c*8 +: 8]),
      .wvalid   (ch_wvalid[c]),
      .wready   (ch_wready[c]),
      .wlast    (ch_wlast[c]),
      .bvalid   (ch_bvalid[c]),
      .bready   (ch_bready[c])
    );
  end
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
  parameter int                NUM_CH     = 8,
  parameter int                DATA_W     = 512,
  parameter int                ADDR_W     = 32,
  parameter int                BURST_LEN  = 16,
  localparam int               TAG_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [TAG_W-1:0]         in_tag,
  input logic                     tag_err,
  input logic [NUM_CH-1:0]        ch_awvalid,
  input logic [NUM_CH-1:0]        ch_awready,
  input logic [NUM_CH*ADDR_W-1:0] ch_awaddr,
  input logic [NUM_CH*8-1:0]      ch_awlen,
  input logic [NUM_CH-1:0]        ch_wvalid,
  input logic [NUM_CH-1:0]        ch_wready,
  input logic [NUM_CH*DATA_W-1:0] ch_wdata,
  input logic [NUM_CH-1:0]        ch_wlast,
  input logic [NUM_CH-1:0]        ch_bvalid,
  input logic [NUM_CH-1:0]        ch_bready
);
  // R7: an error pulse follows an accepted word with an illegal tag
  assert_tag_err_R7: assert property (@(posedge clk) disable iff (rst)
    tag_err |-> $past(in_valid && in_ready) && ({1'b0, $past(in_tag)} >= (TAG_W+1)'(NUM_CH)))
    else $error("tag_err without an illegal accepted tag");

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_last_in_beat_R3: assert property (@(posedge clk) disable iff (rst)
      ch_wlast[c] |-> ch_wvalid[c])
      else $error("wlast outside a data beat");

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (rst)
      ch_awvalid[c] |-> (ch_awlen[c*8 +: 8] <= 8'(BURST_LEN-1)))
      else $error("burst longer than batch size");

    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (rst)
      ch_awvalid[c] && !ch_awready[c] |=> ch_awvalid[c] && $stable(ch_awaddr[c*ADDR_W +: ADDR_W]))
      else $error("address phase dropped before ready");

    assert_w_hold_R8: assert property (@(posedge clk) disable iff (rst)
      ch_wvalid[c] && !ch_wready[c] |=> ch_wvalid[c] && $stable(ch_wdata[c*DATA_W +: DATA_W]))
      else $error("stalled beat changed");

    assert_phase_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(ch_awvalid[c] && ch_wvalid[c]))
      else $error("address and data phase overlap");

    assert_resp_wait_R8: assert property (@(posedge clk) disable iff (rst)
      ch_bready[c] && !ch_bvalid[c] |=> ch_bready[c] && !ch_awvalid[c])
      else $error("new burst before completion");
  end
endmodule

bind burst_batcher bb_checker #(
  .NUM_CH    (NUM_CH),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .BURST_LEN (BURST_LEN)
) u_bb_checker (.*);

// File: tb/burst_batcher_bench.sv
module burst_batcher_bench;
  localparam int NCH = 3;
  localparam int DW  = 16;
  localparam int AW  = 32;
  localparam int DEP = 8;
  localparam int BL  = 4;
  localparam logic [AW-1:0] SPAN = 32'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic [1:0] in_tag = '0;
  logic flush = 1'b0;
  logic tag_err;
  logic [NCH-1:0] ch_awvalid, ch_awready, ch_wvalid, ch_wready, ch_wlast, ch_bvalid, ch_bready;
  logic [NCH*AW-1:0] ch_awaddr;
  logic [NCH*8-1:0]  ch_awlen;
  logic [NCH*DW-1:0] ch_wdata;

  always #10 clk = ~clk;

  burst_batcher #(
    .NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW), .FIFO_DEPTH(DEP), .BURST_LEN(BL), .CH_SPAN(SPAN)
  ) u_burst_batcher (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] exp_q [NCH][64];
  int wr_i [NCH], rd_i [NCH], bursts [NCH], last_len [NCH], cur_len [NCH], cur_beat [NCH];
  logic [AW-1:0] exp_addr [NCH];
  logic aw_done [NCH];
  logic [NCH-1:0] aw_hold = '0;
  logic stall = 1'b0;

  // stimulus table: {tag, expected tag_err}
  localparam logic [2:0] VEC [14] = '{
    {2'd1,1'b0}, {2'd0,1'b0}, {2'd2,1'b0}, {2'd3,1'b1}, {2'd1,1'b0}, {2'd2,1'b0}, {2'd0,1'b0},
    {2'd0,1'b0}, {2'd3,1'b1}, {2'd2,1'b0}, {2'd1,1'b0}, {2'd1,1'b0}, {2'd0,1'b0}, {2'd2,1'b0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      wr_i[c] = 0; rd_i[c] = 0; bursts[c] = 0; last_len[c] = 0;
      cur_len[c] = 0; cur_beat[c] = 0; aw_done[c] = 1'b0;
      exp_addr[c] = AW'(c) * SPAN;
    end
  end

  // responder: updates just after each rising edge
  initial begin
    ch_awready = '0; ch_wready = '0; ch_bvalid = '0;
    forever begin
      @(posedge clk); #2;
      for (int c = 0; c < NCH; c++) begin
        ch_awready[c] = !aw_hold[c];
        ch_wready[c]  = stall ? ((cyc + c) % 3 != 1) : 1'b1;
        ch_bvalid[c]  = ch_bready[c];
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_awvalid[c] && ch_awready[c]) begin
          check(ch_awaddr[c*AW +: AW] == exp_addr[c], "R4 burst address", ch_awaddr[c*AW +: AW], exp_addr[c]);
          cur_len[c] = ch_awlen[c*8 +: 8] + 1;
          cur_beat[c] = 0;
          aw_done[c] = 1'b1;
        end
        if (ch_wvalid[c]) begin
          if (!aw_done[c]) check(1'b0, "R8 beat before address", 1, 0);
          if (ch_wready[c]) begin
            check(rd_i[c] < wr_i[c] && ch_wdata[c*DW +: DW] == exp_q[c][rd_i[c] % 64],
                  "R2 beat data", ch_wdata[c*DW +: DW], exp_q[c][rd_i[c] % 64]);
            check(ch_wlast[c] == (cur_beat[c] == cur_len[c] - 1), "R3 wlast position", ch_wlast[c], cur_beat[c] == cur_len[c] - 1);
            rd_i[c]++;
            cur_beat[c]++;
          end
        end
        if (ch_bvalid[c] && ch_bready[c]) begin
          exp_addr[c] = exp_addr[c] + AW'(cur_len[c] * (DW / 8));
          bursts[c]++;
          last_len[c] = cur_len[c];
          aw_done[c] = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // drive at a falling edge, wait for acceptance, check the error pulse
  task automatic send(input logic [1:0] tag, input logic [DW-1:0] d, input bit exp_err);
    in_valid = 1'b1; in_tag = tag; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (tag < NCH) begin exp_q[tag][wr_i[tag] % 64] = d; wr_i[tag]++; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_err == exp_err, exp_err ? "R7 tag_err pulse" : "R7 no tag_err", tag_err, exp_err);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(ch_awvalid == '0 && ch_wvalid == '0 && ch_bready == '0, "R1 channel outputs idle",
          {ch_awvalid, ch_wvalid, ch_bready}, 0);
    check(tag_err == 1'b0, "R1 tag_err", tag_err, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: scattered tags plus illegal ones (R2 R3 R4 R7)
    for (int i = 0; i < 14; i++)
      send(VEC[i][2:1], DW'(16'hA000 + i), VEC[i][0]);
    settle();
    for (int c = 0; c < NCH; c++) begin
      check(bursts[c] == 1, "R3 one burst per full batch", bursts[c], 1);
      check(last_len[c] == BL, "R3 full burst length", last_len[c], BL);
      check(rd_i[c] == wr_i[c], "R7 R2 no extra or missing beats", rd_i[c], wr_i[c]);
    end

    // second batch on channel 1 with stuttering data ready (R4 R8)
    stall = 1'b1;
    for (int i = 0; i < BL; i++) send(2'd1, DW'(16'hB100 + i), 1'b0);
    settle();
    stall = 1'b0;
    check(bursts[1] == 2, "R4 second burst on channel 1", bursts[1], 2);
    check(exp_addr[1] == SPAN + 16, "R4 address advanced twice", exp_addr[1], SPAN + 16);

    // partial batch waits, flush sends it short (R3 R6)
    for (int i = 0; i < 3; i++) send(2'd2, DW'(16'hC200 + i), 1'b0);
    settle();
    check(bursts[2] == 1, "R3 partial batch held", bursts[2], 1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    settle();
    check(bursts[2] == 2, "R6 flush burst issued", bursts[2], 2);
    check(last_len[2] == 3, "R6 flush burst length", last_len[2], 3);
    check(bursts[0] == 1, "R6 empty channel sends nothing", bursts[0], 1);

    // full buffer stalls input (R5 R9)
    aw_hold[0] = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEP; i++) send(2'd0, DW'(16'hD000 + i), 1'b0);
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_tag = 2'd0; in_data = 16'hD0FF;
    #1;
    check(in_ready == 1'b0, "R5 ready low when full", in_ready, 0);
    check(ch_awvalid[0] == 1'b1, "R9 awvalid held", ch_awvalid[0], 1);
    @(negedge clk); #1;
    check(in_ready == 1'b0 && ch_awvalid[0] == 1'b1, "R5 R9 still stalled", {in_ready, ch_awvalid[0]}, 1);
    aw_hold[0] = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    send(2'd0, 16'hD0FF, 1'b0);
    settle();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    settle();
    check(rd_i[0] == wr_i[0], "R5 no word lost", rd_i[0], wr_i[0]);
    check(last_len[0] == 1, "R6 single leftover burst", last_len[0], 1);
    check(bursts[0] == 4, "R3 burst count channel 0", bursts[0], 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule